// File: doc/BRIEF.md
# Shared-Bus Processor Datapath

This block is a 32-bit datapath in which every storage and arithmetic element hangs off one common bus. Each cycle exactly one source places a word on that bus: the program counter, the ALU result, the selected register-file entry, the word memory at the current address, or the sign-extended immediate taken from the instruction register. Any number of destinations can capture that word at the next rising clock edge. The destinations are the program counter, the instruction register, the address register, the two ALU operand latches, the zero flag, the register file and the memory.

The block has no sequencer of its own. An external controller drives every drive, load and write enable, the ALU function code and the register-field select on every cycle. The controller sees the instruction opcode and the zero flag, and it steps the datapath through fetch, decode and execute by choosing one transfer per cycle. The zero flag is loaded from a zero test on the bus itself, so any value that crosses the bus can be tested, including an ALU difference.

Top module: `bus_datapath`

## Requirements
- R1: When no drive enable is active the bus reads as zero. When exactly one drive enable is active the bus carries that source's value, and `bus_out` shows the bus during the same cycle. Two or more active drive enables in one cycle is a controller error.
- R2: After reset the PC, IR, address register, operand latches A and B, zero flag, all registers and all memory words hold zero.
- R3: The ALU result depends on `alu_fn`. 2'b00 gives A+B, 2'b01 gives NOT(A AND B), 2'b10 gives A−B and 2'b11 gives A+1. All results wrap modulo 2^32.
- R4: Every destination whose load or write enable is high captures the same bus word at one rising edge.
- R5: When `ld_z` is high the zero flag becomes 1 if the bus word is zero and 0 otherwise. When `ld_z` is low the flag holds its value.
- R6: `reg_sel` chooses the register index for both reading and writing. 2'b00 selects IR[27:24], 2'b01 selects IR[23:20], 2'b10 selects IR[3:0] and 2'b11 selects register 0.
- R7: Register 0 always reads as zero, and a write aimed at it leaves it zero.
- R8: A memory read drives the word at the address register onto the bus. `wr_mem` stores the bus word at that address. Only the low log2(MEM_WORDS) address bits are used, so 64 words by default, and higher bits alias.
- R9: The offset source drives IR[19:0] sign-extended to 32 bits, with bit 19 copied into bits 31 to 20.
- R10: `opcode` always shows IR[31:28].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_pc | input | 1 | PC drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_reg | input | 1 | Selected register drives the bus |
| drv_mem | input | 1 | Memory word at the address register drives the bus |
| drv_off | input | 1 | Sign-extended IR offset drives the bus |
| ld_pc | input | 1 | PC captures the bus |
| ld_ir | input | 1 | IR captures the bus |
| ld_mar | input | 1 | Address register captures the bus |
| ld_a | input | 1 | Operand latch A captures the bus |
| ld_b | input | 1 | Operand latch B captures the bus |
| ld_z | input | 1 | Zero flag captures the bus zero test |
| wr_reg | input | 1 | Selected register captures the bus |
| wr_mem | input | 1 | Memory word at the address register captures the bus |
| reg_sel | input | 2 | IR field that indexes the register file |
| alu_fn | input | 2 | ALU function code |
| bus_out | output | 32 | Current bus value |
| z_flag | output | 1 | Zero flag register |
| opcode | output | 4 | IR[31:28] |

## Verification
The hardest state to reach from the ports is any chosen nonzero word. After reset every element holds zero, and the only way a new value enters is through the datapath itself. The stimulus therefore grows constants from the ALU alone. Both operand latches load the doubling A+B each cycle, and A+1 is applied wherever the target has a one bit. When the value is complete, B is reloaded from the undriven bus, which reads zero, so that A+B presents the value unchanged. Those constants then seed the IR fields, the registers, the address register and the memory, which are needed before field selection, memory aliasing or the ALU functions can be checked against distinct operands.

// File: rtl/bdp_pkg.sv
`timescale 1ns/1ps
package bdp_pkg;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_NAND = 2'b01,
    FN_SUB  = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_F0   = 2'b00,
    SEL_F1   = 2'b01,
    SEL_F2   = 2'b10,
    SEL_ZERO = 2'b11
  } reg_sel_e;

  // Instruction register layout (the controller decodes the opcode).
  localparam int OPC_HI = 31;
  localparam int OPC_LO = 28;
  localparam int F0_LO  = 24;
  localparam int F1_LO  = 20;
  localparam int F2_LO  = 0;
  localparam int OFF_W  = 20;

  // Bus source slots, one drive enable each.
  localparam int SRC_PC  = 0;
  localparam int SRC_ALU = 1;
  localparam int SRC_REG = 2;
  localparam int SRC_MEM = 3;
  localparam int SRC_OFF = 4;
  localparam int N_SRC   = 5;

  function automatic logic [31:0] alu_eval(input alu_fn_e fn,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r;
    unique case (fn)
      FN_ADD:  r = a + b;
      FN_NAND: r = ~(a & b);
      FN_SUB:  r = a - b;
      default: r = a + 32'd1;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] sext_offset(input logic [31:0] ir);
    return {{(32-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/bdp_alu.sv
`timescale 1ns/1ps
module bdp_alu
  import bdp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] y
);
  always_comb y = alu_eval(fn, a, b);
endmodule

// File: rtl/bdp_regfile.sv
`timescale 1ns/1ps
module bdp_regfile #(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 16,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] entries [REG_COUNT];
  logic              wr_hit_zero;

  assign wr_hit_zero = wr_en && (idx == '0);

  // Entry 0 has no write path; it is a constant zero.
  assign entries[0] = '0;

  for (genvar g = 1; g < REG_COUNT; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entries[g] <= '0;
      else if (wr_en && idx == IDX_W'(g))
        entries[g] <= wr_data;
    end
  end

  assign rd_data = entries[idx];

  p_r0_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |-> (rd_data == '0));

  p_r0_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_zero |=> (entries[0] == '0));

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx != '0) |=> (entries[$past(idx)] == $past(wr_data)));
endmodule

// File: rtl/bdp_wordmem.sv
`timescale 1ns/1ps
module bdp_wordmem #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] words [MEM_WORDS];
  logic [AW-1:0]     word_idx;
  logic              unused_addr_hi;

  assign word_idx       = addr[AW-1:0];
  assign unused_addr_hi = ^addr[DATA_W-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[word_idx] <= wr_data;
    end
  end

  assign rd_data = words[word_idx];

  p_mem_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (words[$past(word_idx)] == $past(wr_data)));
endmodule

// File: rtl/bus_datapath.sv
`timescale 1ns/1ps
module bus_datapath
  import bdp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 16,
  parameter int MEM_WORDS = 64,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int OPC_W    = OPC_HI - OPC_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_pc,
  input  logic              drv_alu,
  input  logic              drv_reg,
  input  logic              drv_mem,
  input  logic              drv_off,
  input  logic              ld_pc,
  input  logic              ld_ir,
  input  logic              ld_mar,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_z,
  input  logic              wr_reg,
  input  logic              wr_mem,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        alu_fn,
  output logic [DATA_W-1:0] bus_out,
  output logic              z_flag,
  output logic [OPC_W-1:0]  opcode
);
  // ---- state ----
  logic [DATA_W-1:0] pc_q, ir_q, mar_q, a_q, b_q;
  logic              z_q;

  // ---- named internal events ----
  logic [N_SRC-1:0]  drv_vec;
  logic [DATA_W-1:0] src_val [N_SRC];
  logic [DATA_W-1:0] src_gated [N_SRC];
  logic [DATA_W-1:0] bus;
  logic              bus_is_zero;
  logic              bus_conflict;
  logic [IDX_W-1:0]  rf_idx;
  logic [DATA_W-1:0] rf_rd, mem_rd, alu_y, off_val;
  alu_fn_e           fn_e;

  assign fn_e    = alu_fn_e'(alu_fn);
  assign drv_vec = {drv_off, drv_mem, drv_reg, drv_alu, drv_pc};

  // ---- register field select ----
  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_F0:  rf_idx = ir_q[F0_LO +: IDX_W];
      SEL_F1:  rf_idx = ir_q[F1_LO +: IDX_W];
      SEL_F2:  rf_idx = ir_q[F2_LO +: IDX_W];
      default: rf_idx = '0;
    endcase
  end

  assign off_val = sext_offset(ir_q);

  // ---- bus: each source gated by its enable, then OR-merged ----
  assign src_val[SRC_PC]  = pc_q;
  assign src_val[SRC_ALU] = alu_y;
  assign src_val[SRC_REG] = rf_rd;
  assign src_val[SRC_MEM] = mem_rd;
  assign src_val[SRC_OFF] = off_val;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_gated[s] = drv_vec[s] ? src_val[s] : '0;
  end

  always_comb begin
    bus = '0;
    for (int s = 0; s < N_SRC; s++) bus = bus | src_gated[s];
  end

  assign bus_is_zero  = (bus == '0);
  assign bus_conflict = ($countones(drv_vec) > 1);

  // ---- sub-blocks ----
  bdp_alu #(.DATA_W(DATA_W)) u_alu (
    .a  (a_q),
    .b  (b_q),
    .fn (fn_e),
    .y  (alu_y)
  );

  bdp_regfile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (rf_idx),
    .wr_en   (wr_reg),
    .wr_data (bus),
    .rd_data (rf_rd)
  );

  bdp_wordmem #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (mar_q),
    .wr_en   (wr_mem),
    .wr_data (bus),
    .rd_data (mem_rd)
  );

  // ---- bus destinations ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      z_q   <= 1'b0;
    end else begin
      if (ld_pc)  pc_q  <= bus;
      if (ld_ir)  ir_q  <= bus;
      if (ld_mar) mar_q <= bus;
      if (ld_a)   a_q   <= bus;
      if (ld_b)   b_q   <= bus;
      if (ld_z)   z_q   <= bus_is_zero;
    end
  end

  assign bus_out = bus;
  assign z_flag  = z_q;
  assign opcode  = ir_q[OPC_HI:OPC_LO];

  // ---- checks ----
  p_one_driver_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_conflict);

  p_idle_bus_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_vec == '0) |-> bus_is_zero);

  p_z_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_z |=> (z_q == ($past(bus) == '0)));

  p_z_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_z |=> $stable(z_q));

  p_pc_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc && drv_vec == (N_SRC'(1) << SRC_ALU) && fn_e == FN_INC)
      |=> (pc_q == $past(a_q) + DATA_W'(1)));

  p_fanout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && ld_b) |=> (a_q == b_q));
endmodule

// File: tb/sim_bus_datapath.sv
`timescale 1ns/1ps
module sim_bus_datapath;

  localparam int SRC_NONE = 0, S_PC = 1, S_ALU = 2, S_REG = 3, S_MEM = 4, S_OFF = 5;
  localparam logic [7:0] L_PC = 8'h80, L_IR = 8'h40, L_MAR = 8'h20, L_A = 8'h10,
                         L_B = 8'h08, L_Z = 8'h04, L_RF = 8'h02, L_MEM = 8'h01;
  localparam logic [1:0] ADD = 2'b00, NAND = 2'b01, SUB = 2'b10, INC = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic drv_pc, drv_alu, drv_reg, drv_mem, drv_off;
  logic ld_pc, ld_ir, ld_mar, ld_a, ld_b, ld_z, wr_reg, wr_mem;
  logic [1:0] reg_sel, alu_fn;
  logic [31:0] bus_out;
  logic z_flag;
  logic [3:0] opcode;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  bus_datapath u0 (
    .clk(clk), .rst_n(rst_n),
    .drv_pc(drv_pc), .drv_alu(drv_alu), .drv_reg(drv_reg), .drv_mem(drv_mem), .drv_off(drv_off),
    .ld_pc(ld_pc), .ld_ir(ld_ir), .ld_mar(ld_mar), .ld_a(ld_a), .ld_b(ld_b), .ld_z(ld_z),
    .wr_reg(wr_reg), .wr_mem(wr_mem), .reg_sel(reg_sel), .alu_fn(alu_fn),
    .bus_out(bus_out), .z_flag(z_flag), .opcode(opcode)
  );

  // Driver: inputs change 1 ns after the falling edge.
  task automatic tick(input int src, input logic [7:0] ld,
                      input logic [1:0] fn = ADD, input logic [1:0] sel = 2'b00);
    @(negedge clk); #1;
    drv_pc = (src == S_PC);  drv_alu = (src == S_ALU); drv_reg = (src == S_REG);
    drv_mem = (src == S_MEM); drv_off = (src == S_OFF);
    {ld_pc, ld_ir, ld_mar, ld_a, ld_b, ld_z, wr_reg, wr_mem} = ld;
    alu_fn = fn; reg_sel = sel;
  endtask

  task automatic exp_bus(input logic [31:0] v, input string tag);
    q.push_back('{0, v, tag});
  endtask
  task automatic exp_z(input logic v, input string tag);
    q.push_back('{1, {31'd0, v}, tag});
  endtask
  task automatic exp_op(input logic [3:0] v, input string tag);
    q.push_back('{2, {28'd0, v}, tag});
  endtask

  // Constant builder: ends with A = v, B = 0.
  task automatic build(input logic [31:0] v);
    tick(SRC_NONE, L_A | L_B);
    for (int i = 31; i >= 0; i--) begin
      tick(S_ALU, L_A | L_B, ADD);
      if (v[i]) tick(S_ALU, L_A | L_B, INC);
    end
    tick(SRC_NONE, L_B);
  endtask

  // Monitor: compares 3 ns after the falling edge, 1 ns before the rising edge.
  initial begin
    forever begin
      @(negedge clk); #3;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.kind)
          0: got = bus_out;
          1: got = {31'd0, z_flag};
          default: got = {28'd0, opcode};
        endcase
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    {drv_pc, drv_alu, drv_reg, drv_mem, drv_off} = '0;
    {ld_pc, ld_ir, ld_mar, ld_a, ld_b, ld_z, wr_reg, wr_mem} = '0;
    reg_sel = 2'b00; alu_fn = ADD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    tick(S_PC, 8'h00);  exp_bus(32'h0, "R2 pc"); exp_z(1'b0, "R2 z"); exp_op(4'h0, "R2 opcode");
    tick(S_ALU, 8'h00, ADD); exp_bus(32'h0, "R2 a+b");
    tick(S_MEM, 8'h00); exp_bus(32'h0, "R2 mem");
    tick(S_REG, 8'h00, ADD, 2'b00); exp_bus(32'h0, "R2 reg");
    tick(SRC_NONE, 8'h00); exp_bus(32'h0, "R1 idle bus");

    // Instruction word: opcode A, f0=5, f1=3, f2=9, offset bit19 set
    build(32'hA538_0009);
    tick(S_ALU, L_IR, ADD); exp_bus(32'hA538_0009, "R1 alu source");
    tick(S_OFF, 8'h00); exp_bus(32'hFFF8_0009, "R9 sign extend"); exp_op(4'hA, "R10 opcode");

    // R6 field-indexed writes
    build(32'h1234_5678); tick(S_ALU, L_RF, ADD, 2'b00);
    build(32'h0F0F_00F0); tick(S_ALU, L_RF, ADD, 2'b01);
    build(32'hCAFE_F00D); tick(S_ALU, L_RF, ADD, 2'b10);
    build(32'h0000_DEAD); tick(S_ALU, L_RF, ADD, 2'b11);
    tick(S_REG, 8'h00, ADD, 2'b00); exp_bus(32'h1234_5678, "R6 field0");
    tick(S_REG, 8'h00, ADD, 2'b01); exp_bus(32'h0F0F_00F0, "R6 field1");
    tick(S_REG, 8'h00, ADD, 2'b10); exp_bus(32'hCAFE_F00D, "R6 field2");
    tick(S_REG, 8'h00, ADD, 2'b11); exp_bus(32'h0, "R7 reg0 after write");

    // R3 ALU functions, A=r5, B=r3
    tick(S_REG, L_A, ADD, 2'b00);
    tick(S_REG, L_B, ADD, 2'b01);
    tick(S_ALU, 8'h00, ADD);  exp_bus(32'h1234_5678 + 32'h0F0F_00F0, "R3 add");
    tick(S_ALU, 8'h00, NAND); exp_bus(~(32'h1234_5678 & 32'h0F0F_00F0), "R3 nand");
    tick(S_ALU, 8'h00, SUB);  exp_bus(32'h1234_5678 - 32'h0F0F_00F0, "R3 sub");
    tick(S_ALU, 8'h00, INC);  exp_bus(32'h1234_5679, "R3 inc");

    // R4 fan-out into PC, MAR and Z in one edge
    tick(S_ALU, L_PC | L_MAR | L_Z, INC);
    tick(S_PC, 8'h00); exp_bus(32'h1234_5679, "R4 pc loaded"); exp_z(1'b0, "R4 z loaded");

    // R8 memory at word 0x39 (low 6 bits of MAR)
    tick(S_REG, L_MEM, ADD, 2'b10);
    tick(S_MEM, 8'h00); exp_bus(32'hCAFE_F00D, "R8 read back");
    build(32'd121);
    tick(S_ALU, L_MAR, ADD);
    tick(S_MEM, 8'h00); exp_bus(32'hCAFE_F00D, "R8 alias");
    build(32'd3);
    tick(S_ALU, L_MAR, ADD);
    tick(S_MEM, 8'h00); exp_bus(32'h0, "R8 other word");

    // R5 zero flag
    tick(SRC_NONE, L_Z);
    tick(S_REG, L_A | L_B, ADD, 2'b10); exp_z(1'b1, "R5 idle bus zero");
    tick(S_ALU, L_Z, SUB); exp_bus(32'h0, "R5 equal diff");
    tick(S_ALU, 8'h00, ADD); exp_z(1'b1, "R5 set by diff");
    tick(S_PC, 8'h00); exp_z(1'b1, "R5 hold");
    tick(S_PC, L_Z);
    tick(SRC_NONE, 8'h00); exp_z(1'b0, "R5 cleared");

    // R3 PC advance via A+1
    tick(S_PC, L_A);
    tick(S_ALU, L_PC, INC);
    tick(S_PC, 8'h00); exp_bus(32'h1234_567A, "R3 pc advance");

    tick(SRC_NONE, 8'h00);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule